// File: doc/BRIEF.md
# I2C Register-Access Transaction Sequencer

This block runs one complete device-register access on an I2C bus from a single command. It sits above a byte-level bus engine, which it drives through a small request/response interface. A command gives a 7-bit device address, a register address of one to four bytes, a direction and a byte count. The sequencer then issues START, sends the device address, sends the register address, and finishes with one of two data phases. A write sends the data bytes from the write stream. A read issues a repeated START and collects the data bytes onto the read stream. STOP ends the access.

Acknowledge handling on reads follows the usual rule for a receiving master. The engine is told to NACK only the final byte. STOP is requested before that final byte is handed out. The sequencer watches for a missing ACK on transmitted bytes and for lost arbitration. Every wait, whether for the bus to become busy or for a byte to finish, is bounded by a cycle counter. The result is one `done` pulse with a 3-bit error code, where zero means success.

Top module: `i2c_regseq`

## Requirements
- R1: A command whose register-address size is 0 or larger than REG_BYTES_MAX, or whose byte count is 0, ends with `done` and error code 1 and makes no engine request.
- R2: If `bus_busy` is high when a command is accepted, no START is requested and the command ends with error code 2. A START request is only made while `bus_busy` is low.
- R3: After START the sequencer waits for `bus_busy`. `eng_arb` high during that wait ends the command with error code 3. If `bus_busy` has not appeared after TMO_CYC wait cycles, the command ends with error code 5.
- R4: `eng_op` encodes 1 START, 2 repeated START, 3 STOP, 4 transmit byte and 5 receive byte, each valid while `eng_req` is high. The first transmitted byte is `{cmd_dev, 1'b0}`.
- R5: The register address is transmitted as exactly `cmd_reg_bytes` bytes, least significant byte first (byte k is `cmd_reg[8k+7:8k]`).
- R6: For a write, `cmd_len` bytes are taken from the write stream (`wr_valid`/`wr_ready`) and transmitted in arrival order, then STOP is requested. The command ends with error code 0.
- R7: For a read, the register address is followed by a repeated START, the byte `{cmd_dev, 1'b1}` and `cmd_len` receive requests. The received bytes appear on `rd_data` with `rd_valid`, in order.
- R8: `eng_nack` is high for the receive request of the final byte only. When exactly one byte is read, it is already high for that first receive request.
- R9: For the final byte of a read, STOP is requested after its reception completes and before it is presented on `rd_valid`. No STOP is requested between earlier bytes.
- R10: A transmitted byte that completes with `eng_noack` high, and without arbitration loss, ends the command on the next cycle with error code 4. No further engine request is made.
- R11: A byte that completes with `eng_arb` high ends the command on the next cycle with error code 3.
- R12: If a requested byte does not complete within TMO_CYC cycles, the command ends with error code 5.
- R13: After reset, `busy`, `done`, `eng_req`, `wr_ready` and `rd_valid` are low. `busy` stays high from command acceptance until the cycle of `done`. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse, accepted while idle |
| cmd_read | input | 1 | 1 = read access, 0 = write access |
| cmd_dev | input | 7 | Device address |
| cmd_reg | input | 8*REG_BYTES_MAX | Register address |
| cmd_reg_bytes | input | clog2(REG_BYTES_MAX+1) | Number of register-address bytes |
| cmd_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write-stream byte available |
| wr_data | input | 8 | Write-stream byte |
| wr_ready | output | 1 | Sequencer takes the write-stream byte |
| rd_valid | output | 1 | Read byte valid (one cycle) |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| err | output | 3 | Result code, valid with done |
| eng_req | output | 1 | Engine request strobe |
| eng_op | output | 3 | Engine operation code |
| eng_wdata | output | 8 | Byte to transmit |
| eng_nack | output | 1 | Answer the received byte with NACK |
| eng_done | input | 1 | Engine byte operation complete |
| eng_noack | input | 1 | No ACK seen for the transmitted byte |
| eng_arb | input | 1 | Arbitration lost |
| eng_rdata | input | 8 | Received byte |
| bus_busy | input | 1 | Bus busy indication |

## Verification
The assertions check several rules on every cycle: START is never requested while the bus is busy, and `done` is always a single-cycle pulse. `busy` falls only right after `done`, and read data never appears in the same cycle as an engine request. A missing ACK or an arbitration loss on a transmitted byte always leads straight to the matching error code. Some behaviours can only be shown by the bench's scenarios. These include the byte order of the register address, and the NACK placement and STOP-before-last-byte ordering for reads of one, two and four bytes. Each abort path must also stop the request sequence at the right point, and parameter rejection must leave the engine untouched.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_STOP   = 3'd3,
        OP_TX     = 3'd4,
        OP_RX     = 3'd5
    } eng_op_e;

    localparam logic [2:0] ERR_OK    = 3'd0;
    localparam logic [2:0] ERR_PARAM = 3'd1;
    localparam logic [2:0] ERR_BUSY  = 3'd2;
    localparam logic [2:0] ERR_ARB   = 3'd3;
    localparam logic [2:0] ERR_NOACK = 3'd4;
    localparam logic [2:0] ERR_TMO   = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE, S_BUSYW, S_TXI, S_TXW, S_GETW, S_RSI,
        S_RXI, S_RXW, S_STOPR, S_RDOUT, S_STOPW, S_FIN
    } seq_state_e;

    // What the byte in flight on the transmit path is
    typedef enum logic [1:0] {
        K_DEVW, K_REG, K_DATA, K_DEVR
    } tx_kind_e;

    function automatic logic [7:0] addr_byte(input logic [6:0] dev, input logic rd);
        return {dev, rd};
    endfunction

endpackage

// File: rtl/i2c_regseq_wait.sv
// Bounded wait counter: expires on the TMO_CYC-th consecutive cycle of run.
module i2c_regseq_wait #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && (cnt_q == CNT_W'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/i2c_regseq_bytesel.sv
// Picks one byte lane out of the register-address word.
module i2c_regseq_bytesel #(
    parameter int NB    = 4,
    parameter int IDX_W = 2
) (
    input  logic [8*NB-1:0]  word,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    localparam int LANES = 1 << IDX_W;

    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < NB) begin : g_used
            assign lanes[g] = word[8*g +: 8];
        end else begin : g_pad
            assign lanes[g] = 8'h00;
        end
    end

    assign byte_o = lanes[idx];
endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
    import i2c_regseq_pkg::*;
#(
    parameter int REG_BYTES_MAX = 4,
    parameter int LEN_W         = 8,
    parameter int TMO_CYC       = 64,
    localparam int NREG_W       = $clog2(REG_BYTES_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_start,
    input  logic                       cmd_read,
    input  logic [6:0]                 cmd_dev,
    input  logic [8*REG_BYTES_MAX-1:0] cmd_reg,
    input  logic [NREG_W-1:0]          cmd_reg_bytes,
    input  logic [LEN_W-1:0]           cmd_len,
    input  logic                       wr_valid,
    input  logic [7:0]                 wr_data,
    output logic                       wr_ready,
    output logic                       rd_valid,
    output logic [7:0]                 rd_data,
    output logic                       busy,
    output logic                       done,
    output logic [2:0]                 err,
    output logic                       eng_req,
    output logic [2:0]                 eng_op,
    output logic [7:0]                 eng_wdata,
    output logic                       eng_nack,
    input  logic                       eng_done,
    input  logic                       eng_noack,
    input  logic                       eng_arb,
    input  logic [7:0]                 eng_rdata,
    input  logic                       bus_busy
);
    localparam int IDX_W = (REG_BYTES_MAX > 2) ? $clog2(REG_BYTES_MAX) : 1;

    seq_state_e                 state_q;
    tx_kind_e                   kind_q;
    logic [6:0]                 dev_q;
    logic [8*REG_BYTES_MAX-1:0] reg_q;
    logic [NREG_W-1:0]          nreg_q;
    logic [LEN_W-1:0]           len_q;
    logic [LEN_W-1:0]           cnt_q;
    logic [IDX_W-1:0]           idx_q;
    logic                       rd_q;
    logic                       rs_q;
    logic                       nack_q;
    logic [7:0]                 txb_q;
    logic [7:0]                 rdb_q;
    logic [2:0]                 err_q;

    logic                       bad_cmd;
    logic                       tmo;
    logic                       last_byte;
    logic [IDX_W-1:0]           idx_nxt;
    logic [7:0]                 reg_byte;
    logic                       in_txw;
    eng_op_e                    op_c;

    assign bad_cmd   = (cmd_reg_bytes == '0) ||
                       (cmd_reg_bytes > NREG_W'(REG_BYTES_MAX)) ||
                       (cmd_len == '0);
    assign last_byte = (cnt_q == len_q - LEN_W'(1));
    assign idx_nxt   = (kind_q == K_DEVW) ? '0 : idx_q + IDX_W'(1);
    assign in_txw    = (state_q == S_TXW);

    i2c_regseq_wait #(.TMO_CYC(TMO_CYC)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .run     ((state_q == S_BUSYW) || (state_q == S_TXW) || (state_q == S_RXW)),
        .expired (tmo)
    );

    i2c_regseq_bytesel #(.NB(REG_BYTES_MAX), .IDX_W(IDX_W)) u_bytesel (
        .word   (reg_q),
        .idx    (idx_nxt),
        .byte_o (reg_byte)
    );

    // Engine requests are decoded from the state so START can go out in the
    // same cycle that the bus-free check is made.
    always_comb begin
        op_c = OP_IDLE;
        unique case (state_q)
            S_IDLE:          if (cmd_start && !bad_cmd && !bus_busy) op_c = OP_START;
            S_RSI:           op_c = OP_RSTART;
            S_TXI:           op_c = OP_TX;
            S_RXI:           op_c = OP_RX;
            S_STOPR, S_STOPW: op_c = OP_STOP;
            default:         op_c = OP_IDLE;
        endcase
    end

    assign eng_req   = (op_c != OP_IDLE);
    assign eng_op    = op_c;
    assign eng_wdata = txb_q;
    assign eng_nack  = nack_q;
    assign wr_ready  = (state_q == S_GETW);
    assign rd_valid  = (state_q == S_RDOUT);
    assign rd_data   = rdb_q;
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_FIN);
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            kind_q  <= K_DEVW;
            dev_q   <= '0;
            reg_q   <= '0;
            nreg_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            rs_q    <= 1'b0;
            nack_q  <= 1'b0;
            txb_q   <= '0;
            rdb_q   <= '0;
            err_q   <= ERR_OK;
        end else begin
            unique case (state_q)
                S_IDLE: if (cmd_start) begin
                    dev_q  <= cmd_dev;
                    reg_q  <= cmd_reg;
                    nreg_q <= cmd_reg_bytes;
                    len_q  <= cmd_len;
                    rd_q   <= cmd_read;
                    rs_q   <= 1'b0;
                    nack_q <= 1'b0;
                    cnt_q  <= '0;
                    err_q  <= ERR_OK;
                    if (bad_cmd) begin
                        err_q   <= ERR_PARAM;
                        state_q <= S_FIN;
                    end else if (bus_busy) begin
                        err_q   <= ERR_BUSY;
                        state_q <= S_FIN;
                    end else begin
                        state_q <= S_BUSYW;
                    end
                end
                S_BUSYW: begin
                    if (eng_arb) begin
                        err_q   <= ERR_ARB;
                        state_q <= S_FIN;
                    end else if (bus_busy) begin
                        txb_q   <= addr_byte(dev_q, rs_q);
                        kind_q  <= rs_q ? K_DEVR : K_DEVW;
                        state_q <= S_TXI;
                    end else if (tmo) begin
                        err_q   <= ERR_TMO;
                        state_q <= S_FIN;
                    end
                end
                S_TXI: state_q <= S_TXW;
                S_TXW: begin
                    if (eng_done) begin
                        if (eng_arb) begin
                            err_q   <= ERR_ARB;
                            state_q <= S_FIN;
                        end else if (eng_noack) begin
                            err_q   <= ERR_NOACK;
                            state_q <= S_FIN;
                        end else begin
                            unique case (kind_q)
                                K_DEVW, K_REG: begin
                                    if (kind_q == K_REG &&
                                        NREG_W'(idx_q) == nreg_q - NREG_W'(1)) begin
                                        if (rd_q) begin
                                            rs_q    <= 1'b1;
                                            state_q <= S_RSI;
                                        end else begin
                                            state_q <= S_GETW;
                                        end
                                    end else begin
                                        idx_q   <= idx_nxt;
                                        txb_q   <= reg_byte;
                                        kind_q  <= K_REG;
                                        state_q <= S_TXI;
                                    end
                                end
                                K_DATA: begin
                                    cnt_q   <= cnt_q + LEN_W'(1);
                                    state_q <= last_byte ? S_STOPW : S_GETW;
                                end
                                K_DEVR: begin
                                    cnt_q   <= '0;
                                    nack_q  <= (len_q == LEN_W'(1));
                                    state_q <= S_RXI;
                                end
                                default: state_q <= S_FIN;
                            endcase
                        end
                    end else if (tmo) begin
                        err_q   <= ERR_TMO;
                        state_q <= S_FIN;
                    end
                end
                S_GETW: if (wr_valid) begin
                    txb_q   <= wr_data;
                    kind_q  <= K_DATA;
                    state_q <= S_TXI;
                end
                S_RSI: state_q <= S_BUSYW;
                S_RXI: state_q <= S_RXW;
                S_RXW: begin
                    if (eng_done) begin
                        if (eng_arb) begin
                            err_q   <= ERR_ARB;
                            state_q <= S_FIN;
                        end else begin
                            rdb_q   <= eng_rdata;
                            state_q <= last_byte ? S_STOPR : S_RDOUT;
                        end
                    end else if (tmo) begin
                        err_q   <= ERR_TMO;
                        state_q <= S_FIN;
                    end
                end
                S_STOPR: state_q <= S_RDOUT;
                S_RDOUT: begin
                    if (last_byte) begin
                        state_q <= S_FIN;
                    end else begin
                        nack_q  <= (cnt_q == len_q - LEN_W'(2));
                        cnt_q   <= cnt_q + LEN_W'(1);
                        state_q <= S_RXI;
                    end
                end
                S_STOPW: state_q <= S_FIN;
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_regseq_chk.sv
module i2c_regseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic [2:0] err,
    input logic       eng_req,
    input logic [2:0] eng_op,
    input logic       bus_busy,
    input logic       eng_done,
    input logic       eng_noack,
    input logic       eng_arb,
    input logic       rd_valid,
    input logic       in_txw
);
    // R2: START only on a free bus
    p_start_free_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_op == 3'd1) |-> !bus_busy);

    // R13: done lasts one cycle
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13: busy drops only after done
    p_busy_end_r13: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R7: read data is never presented together with an engine request
    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !eng_req);

    // R10: missing ACK aborts with code 4
    p_noack_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (in_txw && eng_done && !eng_arb && eng_noack) |=> (done && err == 3'd4));

    // R11: arbitration loss on a byte aborts with code 3
    p_arb_abort_r11: assert property (@(posedge clk) disable iff (rst)
        (in_txw && eng_done && eng_arb) |=> (done && err == 3'd3));
endmodule

bind i2c_regseq i2c_regseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .bus_busy  (bus_busy),
    .eng_done  (eng_done),
    .eng_noack (eng_noack),
    .eng_arb   (eng_arb),
    .rd_valid  (rd_valid),
    .in_txw    (in_txw)
);

// File: tb/i2c_regseq_tb_top.sv
`timescale 1ns/1ps
module i2c_regseq_tb_top;
    localparam int REG_BYTES_MAX = 4;
    localparam int LEN_W         = 8;
    localparam int TMO_CYC       = 64;
    localparam int NREG_W        = $clog2(REG_BYTES_MAX + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic                       cmd_start = 1'b0;
    logic                       cmd_read  = 1'b0;
    logic [6:0]                 cmd_dev   = '0;
    logic [8*REG_BYTES_MAX-1:0] cmd_reg   = '0;
    logic [NREG_W-1:0]          cmd_reg_bytes = '0;
    logic [LEN_W-1:0]           cmd_len   = '0;
    logic                       wr_valid  = 1'b0;
    logic [7:0]                 wr_data   = '0;
    logic                       wr_ready, rd_valid, busy, done;
    logic [7:0]                 rd_data, eng_wdata;
    logic [2:0]                 err, eng_op;
    logic                       eng_req, eng_nack;
    logic                       eng_done  = 1'b0;
    logic                       eng_noack = 1'b0;
    logic                       eng_arb   = 1'b0;
    logic [7:0]                 eng_rdata = '0;
    logic                       bus_line  = 1'b0;
    logic                       force_busy = 1'b0;
    logic                       bus_busy;
    assign bus_busy = bus_line | force_busy;

    i2c_regseq #(.REG_BYTES_MAX(REG_BYTES_MAX), .LEN_W(LEN_W), .TMO_CYC(TMO_CYC)) dut_i (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_reg_bytes(cmd_reg_bytes),
        .cmd_len(cmd_len), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err), .eng_req(eng_req),
        .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_noack(eng_noack), .eng_arb(eng_arb),
        .eng_rdata(eng_rdata), .bus_busy(bus_busy)
    );

    // Driver-owned configuration and expected-event scoreboard
    logic [11:0] exp_ev [0:31];
    int          exp_n    = 0;
    int          cfg_len  = 0;
    bit          cfg_wr   = 0;
    bit          line_clr = 0;
    int          f_noack  = -1;
    int          f_arb    = -1;
    int          f_hang   = -1;
    bit          f_nobusy = 0;
    bit          f_arbst  = 0;
    string       tag      = "R4";

    // Env-owned state
    int  ev_rd = 0, rd_n = 0, wr_n = 0, tx_n = 0, rx_n = 0, dcnt = 0, bcnt = 0;
    bit  pend_tx = 0, took = 0, done_seen = 0;
    logic [2:0] done_err = '0;
    int  e_checks = 0, e_fails = 0, d_checks = 0, d_fails = 0;

    task automatic echk(input bit ok, input string req, input string what,
                        input int act, input int exp);
        e_checks++;
        if (!ok) begin
            e_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic dchk(input bit ok, input string req, input string what,
                        input int act, input int exp);
        d_checks++;
        if (!ok) begin
            d_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor, engine model and write-stream source, away from the clock edge
    always begin
        @(negedge clk);
        #1;
        if (line_clr) begin
            ev_rd = 0; rd_n = 0; wr_n = 0; tx_n = 0; rx_n = 0;
            dcnt = 0; bcnt = 0; took = 0; done_seen = 0;
            bus_line = 1'b0; eng_arb = 1'b0; eng_noack = 1'b0;
        end
        if (!rst) begin
            if (eng_req) begin
                logic [11:0] ev;
                ev = {eng_op, (eng_op == 3'd5) ? eng_nack : 1'b0,
                      (eng_op == 3'd4) ? eng_wdata : 8'h00};
                if (ev_rd >= exp_n) begin
                    echk(0, tag, "unexpected engine request", ev, 0);
                end else begin
                    echk(ev == exp_ev[ev_rd], tag, "engine request", ev, exp_ev[ev_rd]);
                    ev_rd++;
                end
            end
            if (rd_valid) begin
                echk(rd_data == 8'(8'hA0 + rd_n), "R7", "read byte",
                     rd_data, 8'(8'hA0 + rd_n));
                if (rd_n + 1 == cfg_len)
                    echk(ev_rd == exp_n, "R9", "STOP before last read byte", ev_rd, exp_n);
                rd_n++;
            end
            if (done) begin
                done_seen = 1;
                done_err  = err;
            end
        end
        // engine model
        eng_done = 1'b0;
        if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) begin
                eng_done = 1'b1;
                if (pend_tx) begin
                    eng_noack = (tx_n == f_noack);
                    eng_arb   = (tx_n == f_arb);
                    tx_n++;
                end else begin
                    eng_noack = 1'b0;
                    eng_rdata = 8'(8'hA0 + rx_n);
                    rx_n++;
                end
            end
        end
        if (bcnt > 0) begin
            bcnt--;
            if (bcnt == 0) bus_line = 1'b1;
        end
        if (eng_req && !rst) begin
            case (eng_op)
                3'd1, 3'd2: begin
                    if (f_arbst)        eng_arb = 1'b1;
                    else if (!f_nobusy) bcnt = 2;
                end
                3'd3: bus_line = 1'b0;
                3'd4: begin pend_tx = 1; if (tx_n != f_hang) dcnt = 3; end
                3'd5: begin pend_tx = 0; dcnt = 3; end
                default: ;
            endcase
        end
        // write stream
        if (took) wr_n++;
        wr_valid = cfg_wr && (wr_n < cfg_len);
        wr_data  = 8'(8'h30 + 7 * wr_n);
        took     = wr_valid && wr_ready;
    end

    task automatic run_cmd(input string t, input bit rd, input logic [6:0] dev,
                           input logic [31:0] regv, input int nreg, input int len,
                           input int exp_err, input int cut);
        int n;
        n = 0;
        if (nreg >= 1 && nreg <= REG_BYTES_MAX && len >= 1) begin
            exp_ev[n++] = {3'd1, 9'd0};
            exp_ev[n++] = {3'd4, 1'b0, dev, 1'b0};
            for (int i = 0; i < nreg; i++) exp_ev[n++] = {3'd4, 1'b0, 8'(regv >> (8 * i))};
            if (rd) begin
                exp_ev[n++] = {3'd2, 9'd0};
                exp_ev[n++] = {3'd4, 1'b0, dev, 1'b1};
                for (int i = 0; i < len; i++) exp_ev[n++] = {3'd5, (i == len - 1), 8'd0};
            end else begin
                for (int i = 0; i < len; i++) exp_ev[n++] = {3'd4, 1'b0, 8'(8'h30 + 7 * i)};
            end
            exp_ev[n++] = {3'd3, 9'd0};
        end
        if (cut >= 0 && cut < n) n = cut;
        @(negedge clk);
        line_clr = 1; tag = t; exp_n = n; cfg_len = len; cfg_wr = !rd;
        @(negedge clk);
        line_clr = 0;
        cmd_read = rd; cmd_dev = dev; cmd_reg = regv;
        cmd_reg_bytes = NREG_W'(nreg); cmd_len = LEN_W'(len);
        cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        #2;
        dchk(busy == 1'b1, "R13", "busy after accept", busy, 1);
        for (int c = 0; c < 3000 && !done_seen; c++) @(negedge clk);
        #2;
        dchk(done_seen, t, "done seen", done_seen, 1);
        dchk(done_err == 3'(exp_err), t, "error code", done_err, exp_err);
        dchk(ev_rd == exp_n, t, "engine requests consumed", ev_rd, exp_n);
        if (rd && cut < 0) dchk(rd_n == len, "R7", "read byte count", rd_n, len);
        @(negedge clk);
        #2;
        dchk(busy == 1'b0, "R13", "idle after done", busy, 0);
        f_noack = -1; f_arb = -1; f_hang = -1; f_nobusy = 0; f_arbst = 0; force_busy = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 e_checks + d_checks + 1, e_fails + d_fails + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        #2;
        // R13: reset state
        dchk(!busy && !done && !eng_req && !wr_ready && !rd_valid, "R13", "reset outputs",
             {busy, done, eng_req, wr_ready, rd_valid}, 0);

        // R4 R5 R6: write, two register bytes, three data bytes
        run_cmd("R6", 0, 7'h50, 32'h0000_1234, 2, 3, 0, -1);
        // R7 R8 R9: single-byte read, NACK from the first receive
        run_cmd("R8", 1, 7'h68, 32'h0000_00A5, 1, 1, 0, -1);
        // R5 R7 R8: four-byte register, four data bytes
        run_cmd("R5", 1, 7'h1C, 32'h1122_3344, 4, 4, 0, -1);
        // R8 R9: two-byte read
        run_cmd("R9", 1, 7'h2A, 32'h0000_0077, 1, 2, 0, -1);
        // R6: three register bytes, one data byte
        run_cmd("R4", 0, 7'h7F, 32'h00AB_CDEF, 3, 1, 0, -1);
        // R1: parameter rejection
        run_cmd("R1", 0, 7'h10, 32'h0, 0, 2, 1, 0);
        run_cmd("R1", 1, 7'h10, 32'h0, 5, 2, 1, 0);
        run_cmd("R1", 0, 7'h10, 32'h5, 1, 0, 1, 0);
        // R2: bus busy at command
        force_busy = 1;
        run_cmd("R2", 0, 7'h22, 32'h1, 1, 1, 2, 0);
        // R3: busy never appears / arbitration lost after START
        f_nobusy = 1;
        run_cmd("R3", 0, 7'h22, 32'h1, 1, 1, 5, 1);
        f_arbst = 1;
        run_cmd("R3", 1, 7'h22, 32'h1, 1, 1, 3, 1);
        // R10: no ACK on first register byte, and on the read address byte
        f_noack = 1;
        run_cmd("R10", 0, 7'h33, 32'h0000_0102, 2, 2, 4, 3);
        f_noack = 2;
        run_cmd("R10", 1, 7'h33, 32'h0000_0009, 1, 2, 4, 5);
        // R11: arbitration lost on the device-address byte
        f_arb = 0;
        run_cmd("R11", 0, 7'h44, 32'h0000_0009, 1, 2, 3, 2);
        // R12: first data byte never completes
        f_hang = 2;
        run_cmd("R12", 0, 7'h55, 32'h0000_0009, 1, 2, 5, 4);
        // recovery after aborts
        run_cmd("R6", 0, 7'h05, 32'h0000_00F0, 1, 2, 0, -1);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 e_checks + d_checks, e_fails + d_fails);
        $finish;
    end
endmodule